// File: doc/BRIEF.md
# Memory lock bit protection unit

This block holds the protection byte that guards a microcontroller's nonvolatile memories. From that byte it decides whether each access may go ahead. One group of requests comes from an external programming port: flash write, EEPROM write, verify/read-back, fuse write and lock write. The other group comes from the running program: self-programming writes into the application section, and table reads that target the application section. For every request the block returns a grant. It also raises an interrupt-block flag when execution sits in the application section while the interrupt vectors live in the boot section.

The protection byte can only become more restrictive during normal operation. A write combines the new data with the stored value by bitwise AND, so a bit can go from 1 to 0 and never back. Only a chip-erase pulse sets every bit to 1 again. Bits 7:6 carry no function and always read as 1. Bits 5:4 are kept in storage but drive no decision. All grants are combinational from the stored byte and the current request lines.

Top module: `nvm_guard`

## Requirements
- R1: While reset is asserted, and after it, until the first write, `lock_q` reads 8'hFF. A value of 1 means unprogrammed.
- R2: A `lk_wr` pulse without `erase` changes `lock_q` at the next rising clock edge to the old value ANDed with `lk_wdata`. Bits are never set back to 1 this way, and bits 7:6 always read 1.
- R3: An `erase` pulse sets `lock_q` to 8'hFF at the next edge. This holds even when `lk_wr` is high in the same cycle.
- R4: With bit1=1 and bit0=1 (open mode), each external grant equals its request.
- R5: With bit1=1 and bit0=0 (write-locked mode), flash write, EEPROM write and fuse write are denied. Verify and lock write are granted on request.
- R6: With bit1=0, regardless of bit0, every external grant is denied. In this mode a `lk_wr` leaves bits 5:2 unchanged, while bits 1:0 still follow the AND rule.
- R7: `spm_app_wr_ok` equals `spm_app_wr_req` when bit2=1 and is 0 when bit2=0.
- R8: `tbl_app_rd_ok` is denied when bit3=0 and `exec_in_boot`=1. Otherwise it equals `tbl_app_rd_req`.
- R9: `irq_block` is 1 exactly when bit3=0, `vec_in_boot`=1 and `exec_in_boot`=0.
- R10: No grant is ever asserted without its request, and grants respond in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_wr | input | 1 | Protection byte write strobe |
| lk_wdata | input | 8 | Protection byte write data |
| erase | input | 1 | Chip-erase pulse |
| ext_flash_wr_req | input | 1 | External flash write request |
| ext_eep_wr_req | input | 1 | External EEPROM write request |
| ext_verify_req | input | 1 | External verify/read request |
| ext_fuse_wr_req | input | 1 | External fuse write request |
| ext_lock_wr_req | input | 1 | External lock write request |
| spm_app_wr_req | input | 1 | Self-programming write to application section |
| tbl_app_rd_req | input | 1 | Table read of application section |
| exec_in_boot | input | 1 | Current code runs from the boot section |
| vec_in_boot | input | 1 | Interrupt vectors are placed in the boot section |
| ext_flash_wr_ok | output | 1 | Flash write grant |
| ext_eep_wr_ok | output | 1 | EEPROM write grant |
| ext_verify_ok | output | 1 | Verify grant |
| ext_fuse_wr_ok | output | 1 | Fuse write grant |
| ext_lock_wr_ok | output | 1 | Lock write grant |
| spm_app_wr_ok | output | 1 | Self-programming write grant |
| tbl_app_rd_ok | output | 1 | Table read grant |
| irq_block | output | 1 | Interrupt disable flag |
| lock_q | output | 8 | Stored protection byte |

## Verification
A corrupted stored byte shows up on `lock_q` in the cycle after the faulty update. It shows up on the grants in that same cycle, as soon as a request arrives, because nothing is registered between the byte and the outputs. A bit that climbs back to 1 without an erase, or boot bits that move while the lock is fully set, is caught by comparing `lock_q` against a bench model one edge after each write. A wrong mode decode appears immediately as a grant that differs from the model for the same request and context pattern.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;
  localparam int LOCK_W     = 8;
  localparam int EXT_CH     = 5;
  localparam int BOOT_LO    = 2;
  localparam int BOOT_HI    = 5;
  localparam logic [LOCK_W-1:0] SPARE_MASK = 8'hC0;
  localparam logic [LOCK_W-1:0] BOOT_MASK  = 8'h3C;

  typedef enum logic [1:0] {
    LB_FULL  = 2'b00,
    LB_WLOCK = 2'b01,
    LB_OPEN  = 2'b10
  } lb_mode_e;

  function automatic lb_mode_e lb_decode(input logic [1:0] pair);
    case (pair)
      2'b11:   return LB_OPEN;
      2'b10:   return LB_WLOCK;
      default: return LB_FULL;
    endcase
  endfunction

  function automatic logic [LOCK_W-1:0] lock_merge(
      input logic [LOCK_W-1:0] cur,
      input logic [LOCK_W-1:0] data,
      input logic              freeze_boot);
    logic [LOCK_W-1:0] keep;
    keep = freeze_boot ? BOOT_MASK : '0;
    return (cur & (data | keep)) | SPARE_MASK;
  endfunction
endpackage

// File: rtl/nvm_guard_store.sv
module nvm_guard_store
  import nvm_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [LOCK_W-1:0] wdata,
  input  logic              erase,
  input  logic              freeze_boot,
  output logic [LOCK_W-1:0] q
);
  logic [LOCK_W-1:0] nxt;

  always_comb begin
    if (erase)   nxt = '1;
    else if (wr) nxt = lock_merge(q, wdata, freeze_boot);
    else         nxt = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= nxt;
  end
endmodule

// File: rtl/nvm_guard_ext.sv
module nvm_guard_ext
  import nvm_guard_pkg::*;
(
  input  lb_mode_e          mode,
  input  logic [EXT_CH-1:0] req,
  output logic [EXT_CH-1:0] ok
);
  // channel order: 0 flash wr, 1 eeprom wr, 2 verify, 3 fuse wr, 4 lock wr
  logic [EXT_CH-1:0] allow;

  always_comb begin
    allow = '0;
    case (mode)
      LB_OPEN:  allow = '1;
      LB_WLOCK: allow = 5'b10100;
      default:  allow = '0;
    endcase
  end

  for (genvar c = 0; c < EXT_CH; c++) begin : g_ch
    assign ok[c] = req[c] & allow[c];
  end
endmodule

// File: rtl/nvm_guard_self.sv
module nvm_guard_self (
  input  logic blb01,
  input  logic blb02,
  input  logic exec_in_boot,
  input  logic vec_in_boot,
  input  logic wr_req,
  input  logic rd_req,
  output logic wr_ok,
  output logic rd_ok,
  output logic irq_block
);
  logic rd_fence;
  assign rd_fence  = ~blb02 & exec_in_boot;
  assign wr_ok     = wr_req & blb01;
  assign rd_ok     = rd_req & ~rd_fence;
  assign irq_block = ~blb02 & vec_in_boot & ~exec_in_boot;
endmodule

// File: rtl/nvm_guard.sv
module nvm_guard
  import nvm_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_wr,
  input  logic [LOCK_W-1:0] lk_wdata,
  input  logic              erase,
  input  logic              ext_flash_wr_req,
  input  logic              ext_eep_wr_req,
  input  logic              ext_verify_req,
  input  logic              ext_fuse_wr_req,
  input  logic              ext_lock_wr_req,
  input  logic              spm_app_wr_req,
  input  logic              tbl_app_rd_req,
  input  logic              exec_in_boot,
  input  logic              vec_in_boot,
  output logic              ext_flash_wr_ok,
  output logic              ext_eep_wr_ok,
  output logic              ext_verify_ok,
  output logic              ext_fuse_wr_ok,
  output logic              ext_lock_wr_ok,
  output logic              spm_app_wr_ok,
  output logic              tbl_app_rd_ok,
  output logic              irq_block,
  output logic [LOCK_W-1:0] lock_q
);
  lb_mode_e          lb_mode;
  logic              boot_frozen;
  logic [EXT_CH-1:0] ext_req;
  logic [EXT_CH-1:0] ext_ok;

  assign lb_mode     = lb_decode(lock_q[1:0]);
  assign boot_frozen = (lb_mode == LB_FULL);

  nvm_guard_store u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (lk_wr),
    .wdata       (lk_wdata),
    .erase       (erase),
    .freeze_boot (boot_frozen),
    .q           (lock_q)
  );

  assign ext_req = {ext_lock_wr_req, ext_fuse_wr_req, ext_verify_req,
                    ext_eep_wr_req, ext_flash_wr_req};

  nvm_guard_ext u_ext (
    .mode (lb_mode),
    .req  (ext_req),
    .ok   (ext_ok)
  );

  assign ext_flash_wr_ok = ext_ok[0];
  assign ext_eep_wr_ok   = ext_ok[1];
  assign ext_verify_ok   = ext_ok[2];
  assign ext_fuse_wr_ok  = ext_ok[3];
  assign ext_lock_wr_ok  = ext_ok[4];

  nvm_guard_self u_self (
    .blb01        (lock_q[BOOT_LO]),
    .blb02        (lock_q[BOOT_LO+1]),
    .exec_in_boot (exec_in_boot),
    .vec_in_boot  (vec_in_boot),
    .wr_req       (spm_app_wr_req),
    .rd_req       (tbl_app_rd_req),
    .wr_ok        (spm_app_wr_ok),
    .rd_ok        (tbl_app_rd_ok),
    .irq_block    (irq_block)
  );
endmodule

// File: rtl/nvm_guard_chk.sv
module nvm_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lk_wr,
  input logic [7:0] lk_wdata,
  input logic       erase,
  input logic       boot_frozen,
  input logic [4:0] ext_req,
  input logic [4:0] ext_ok,
  input logic       spm_app_wr_req,
  input logic       tbl_app_rd_req,
  input logic       exec_in_boot,
  input logic       vec_in_boot,
  input logic       spm_app_wr_ok,
  input logic       tbl_app_rd_ok,
  input logic       irq_block,
  input logic [7:0] lock_q
);
  // R2: no bit returns to 1 unless erase was present
  p_no_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !erase |=> ((lock_q[5:0] & ~$past(lock_q[5:0])) == 6'b0));

  // R2: spare bits read 1
  p_spare_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[7:6] == 2'b11);

  // R3: erase wins
  p_erase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> lock_q == 8'hFF);

  // R6: boot bits held while fully locked
  p_boot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_frozen && !erase) |=> $stable(lock_q[5:2]));

  // R6: no external grant when LB2 programmed
  p_ext_deny_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q[1] |-> ext_ok == 5'b0);

  // R5: flash, eeprom, fuse need open mode
  p_wlock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q[0] |-> (ext_ok & 5'b01011) == 5'b0);

  // R7
  p_spm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q[2] |-> !spm_app_wr_ok);

  // R8
  p_tbl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q[3] && exec_in_boot) |-> !tbl_app_rd_ok);

  // R9
  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_block |-> (!lock_q[3] && vec_in_boot && !exec_in_boot));

  // R10: grants only with request
  p_grant_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_ok & ~ext_req) == 5'b0) && (!spm_app_wr_ok || spm_app_wr_req)
    && (!tbl_app_rd_ok || tbl_app_rd_req));

  // R2: plain write result when boot bits are not frozen
  p_and_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_wr && !erase && !boot_frozen) |=>
      lock_q == (($past(lock_q) & $past(lk_wdata)) | 8'hC0));
endmodule

bind nvm_guard nvm_guard_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .lk_wr          (lk_wr),
  .lk_wdata       (lk_wdata),
  .erase          (erase),
  .boot_frozen    (boot_frozen),
  .ext_req        (ext_req),
  .ext_ok         (ext_ok),
  .spm_app_wr_req (spm_app_wr_req),
  .tbl_app_rd_req (tbl_app_rd_req),
  .exec_in_boot   (exec_in_boot),
  .vec_in_boot    (vec_in_boot),
  .spm_app_wr_ok  (spm_app_wr_ok),
  .tbl_app_rd_ok  (tbl_app_rd_ok),
  .irq_block      (irq_block),
  .lock_q         (lock_q)
);

// File: tb/nvm_guard_test.sv
module nvm_guard_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       lk_wr = 0;
  logic [7:0] lk_wdata = 8'hFF;
  logic       erase = 0;
  logic [6:0] req = 0;
  logic       exec_in_boot = 0;
  logic       vec_in_boot = 0;
  logic [7:0] grants;
  logic [7:0] lock_q;

  always #4 clk = ~clk;

  nvm_guard uut (
    .clk(clk), .rst_n(rst_n), .lk_wr(lk_wr), .lk_wdata(lk_wdata), .erase(erase),
    .ext_flash_wr_req(req[0]), .ext_eep_wr_req(req[1]), .ext_verify_req(req[2]),
    .ext_fuse_wr_req(req[3]), .ext_lock_wr_req(req[4]),
    .spm_app_wr_req(req[5]), .tbl_app_rd_req(req[6]),
    .exec_in_boot(exec_in_boot), .vec_in_boot(vec_in_boot),
    .ext_flash_wr_ok(grants[0]), .ext_eep_wr_ok(grants[1]), .ext_verify_ok(grants[2]),
    .ext_fuse_wr_ok(grants[3]), .ext_lock_wr_ok(grants[4]),
    .spm_app_wr_ok(grants[5]), .tbl_app_rd_ok(grants[6]), .irq_block(grants[7]),
    .lock_q(lock_q)
  );

  typedef struct {
    logic [7:0] lk;
    logic [7:0] gr;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] model = 8'hFF;

  function automatic logic [7:0] want_grants(logic [7:0] lk, logic [6:0] r,
                                             logic boot, logic vec);
    logic [7:0] g;
    logic open_m, wlock;
    open_m = (lk[1:0] == 2'b11);
    wlock  = (lk[1:0] == 2'b10);
    g[0] = r[0] && open_m;
    g[1] = r[1] && open_m;
    g[2] = r[2] && (open_m || wlock);
    g[3] = r[3] && open_m;
    g[4] = r[4] && (open_m || wlock);
    g[5] = r[5] && lk[2];
    g[6] = r[6] && !(lk[3] == 1'b0 && boot);
    g[7] = (lk[3] == 1'b0) && vec && !boot;
    return g;
  endfunction

  function automatic logic [7:0] want_next(logic [7:0] lk, logic w, logic [7:0] d, logic e);
    logic [7:0] dd;
    if (e) return 8'hFF;
    if (!w) return lk;
    dd = d;
    if (lk[1] == 1'b0) dd[5:2] = 4'b1111;
    return (lk & dd) | 8'b1100_0000;
  endfunction

  task automatic step(logic w, logic [7:0] d, logic e, logic [6:0] r,
                      logic boot, logic vec, string tag);
    item_t it;
    @(negedge clk);
    #1;
    lk_wr = w; lk_wdata = d; erase = e; req = r;
    exec_in_boot = boot; vec_in_boot = vec;
    it.lk = model;
    it.gr = want_grants(model, r, boot, vec);
    it.tag = tag;
    q.push_back(it);
    model = want_next(model, w, d, e);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (lock_q !== it.lk) begin
          fails++;
          $display("FAIL %s lock_q actual %h expected %h", it.tag, lock_q, it.lk);
        end
        checks++;
        if (grants !== it.gr) begin
          fails++;
          $display("FAIL %s grants actual %b expected %b", it.tag, grants, it.gr);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++;
    if (lock_q !== 8'hFF) begin
      fails++;
      $display("FAIL R1 reset lock_q actual %h expected ff", lock_q);
    end
    rst_n = 1;
    // R1 / R4: open mode, every request
    step(0, 8'hFF, 0, 7'h7F, 0, 0, "R1 R4 open");
    step(0, 8'hFF, 0, 7'h7F, 1, 1, "R4 R8 open boot");
    step(0, 8'hFF, 0, 7'h00, 0, 1, "R10 no req");
    step(0, 8'hFF, 0, 7'h15, 0, 0, "R10 partial req");
    // R2: spare bits cannot be cleared
    step(1, 8'h3F, 0, 7'h00, 0, 0, "R2 spare write");
    step(0, 8'hFF, 0, 7'h7F, 0, 0, "R2 spare read");
    // R5: write-locked mode
    step(1, 8'hFE, 0, 7'h00, 0, 0, "R2 clear LB1");
    step(0, 8'hFF, 0, 7'h7F, 0, 0, "R5 wlock");
    step(1, 8'hFF, 0, 7'h1F, 0, 0, "R2 no set back");
    step(0, 8'hFF, 0, 7'h1F, 1, 0, "R5 wlock again");
    // R7: BLB01 programmed
    step(1, 8'hFB, 0, 7'h00, 0, 0, "R7 clear BLB01");
    step(0, 8'hFF, 0, 7'h60, 0, 0, "R7 spm denied");
    // R8 R9: BLB02 programmed
    step(1, 8'hF7, 0, 7'h00, 0, 0, "R8 clear BLB02");
    step(0, 8'hFF, 0, 7'h60, 1, 1, "R8 tbl from boot");
    step(0, 8'hFF, 0, 7'h60, 0, 1, "R9 irq app vec boot");
    step(0, 8'hFF, 0, 7'h60, 0, 0, "R9 vec in app");
    // R3: erase beats write
    step(1, 8'h00, 1, 7'h00, 0, 0, "R3 erase+write");
    step(0, 8'hFF, 0, 7'h7F, 0, 1, "R3 after erase");
    // R6: full lock, boot bits frozen
    step(1, 8'hFC, 0, 7'h00, 0, 0, "R6 full lock");
    step(1, 8'hC3, 0, 7'h7F, 0, 0, "R6 boot write");
    step(0, 8'hFF, 0, 7'h7F, 1, 1, "R6 boot frozen");
    // R6: undefined pair LB2=0 LB1=1
    step(0, 8'hFF, 1, 7'h00, 0, 0, "R3 erase");
    step(1, 8'hFD, 0, 7'h00, 0, 0, "R6 set 01");
    step(0, 8'hFF, 0, 7'h7F, 0, 0, "R6 01 denies");
    step(1, 8'hF3, 0, 7'h1F, 0, 0, "R6 01 boot write");
    step(0, 8'hFF, 0, 7'h7F, 0, 0, "R6 01 frozen");
    step(0, 8'hFF, 0, 7'h00, 0, 0, "idle");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule